// File: doc/BRIEF.md
# SDRAM Command Issuer with Per-Bank Timing Tracker

This block sits between a memory controller's scheduler and the SDRAM pins. The scheduler presents one abstract request at a time over a valid/ready handshake. The request types are row open, column read, column write, bank close (one bank or every bank), burst stop, refresh and mode load. The block turns each accepted request into the chip-select, row-strobe, column-strobe and write-enable levels, together with the bank and address buses. All of these are registered, so they appear one clock after acceptance. On a clock with nothing accepted it drives a no-operation.

For every bank the block keeps a row-open flag and a down-counter of cycles during which the bank may not take a new command. A request aimed at a bank whose counter is non-zero waits with ready low. Requests that touch every bank wait until all counters are zero. Address bit 10 has a different meaning per command: it asks for a close-after-burst on a read or write, and it selects close-all on a bank close. When the memory runs in full-page bursts, close-after-burst is suppressed.

Top module: `sdram_cmd_issuer`

## Requirements
- R1: While reset is asserted and right after it, the pins carry a no-operation (cs_n,ras_n,cas_n,we_n = 0,1,1,1) and every bank reads as closed in `bank_open`.
- R2: On every clock edge where no request is accepted (valid low, or valid high with ready low), the pins show a no-operation on the following cycle.
- R3: An accepted request shows on the pins in the next cycle, encoded as {cs_n,ras_n,cas_n,we_n}: op 0 row open = 0011, op 1 read = 0101, op 2 write = 0100, op 3 close = 0010, op 4 burst stop = 0110, op 5 refresh = 0001, op 6 mode load = 0000.
- R4: A row open drives the 12-bit row on A0..A11 and the bank on BA, with A12 low. The bank's `bank_open` bit then goes high.
- R5: A read or write drives the 9-bit column on A0..A8 and the bank on BA. A10 equals the request's close-after-burst flag for that command only, and all other address bits are low.
- R6: With `cfg_full_page` high, a read or write drives A10 low whatever its flag. The bank stays open and is not blocked.
- R7: A single-bank close drives A10 low and the bank on BA, and it clears that bank's open bit. That bank accepts its next command no sooner than T_RP cycles later. Other banks are not delayed.
- R8: A close-all drives A10 high and BA zero, ignoring the bank field. It clears every open bit and blocks every bank for T_RP cycles.
- R9: A read or write with an effective close-after-burst clears the bank's open bit. The bank then accepts its next command no sooner than BURST_LEN+T_RP cycles after that read or write, which counts T_RP from the burst's end.
- R10: After a row open, the same bank accepts a read or write no sooner than T_RCD cycles later.
- R11: Refresh and mode load wait until every bank is unblocked. Mode load places the 12-bit op-code on A0..A11 with A12 low and BA zero.
- R12: A burst stop is never held off and drives zero on BA and the address bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_full_page | input | 1 | Memory is in full-page burst mode |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this edge when valid |
| req_op | input | 3 | Request type (codes in R3) |
| req_bank | input | BA_W | Target bank |
| req_arg | input | ROW_W | Row, column, or mode op-code |
| req_auto_pre | input | 1 | Close bank after this read/write burst |
| req_all | input | 1 | Close applies to every bank |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Address bus A0..A12 |
| bank_open | output | NUM_BANKS | Per-bank row-open flags |

## Verification
The hardest condition to reach from the ports is overlapping blocking windows. One bank is waiting out a close-after-burst window while a neighbour is opened and closed, and then a bank-wide command has to wait on the last of those windows. The stimulus issues a close-after-burst write to bank 0 and immediately opens bank 1, then reopens bank 0 and measures the acceptance cycle against the write rather than against the most recent request. It later issues a burst stop and a refresh right behind a close-all, so that one request passes at once and the other waits out T_RP.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    typedef enum logic [2:0] {
        OP_ACT = 3'd0,
        OP_RD  = 3'd1,
        OP_WR  = 3'd2,
        OP_PRE = 3'd3,
        OP_BST = 3'd4,
        OP_REF = 3'd5,
        OP_LMR = 3'd6
    } op_e;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] PIN_NOP = 4'b0111;
    localparam logic [3:0] PIN_ACT = 4'b0011;
    localparam logic [3:0] PIN_RD  = 4'b0101;
    localparam logic [3:0] PIN_WR  = 4'b0100;
    localparam logic [3:0] PIN_BST = 4'b0110;
    localparam logic [3:0] PIN_PRE = 4'b0010;
    localparam logic [3:0] PIN_REF = 4'b0001;
    localparam logic [3:0] PIN_LMR = 4'b0000;

endpackage

// File: rtl/sdc_bank_timer.sv
module sdc_bank_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             set_open,
    input  logic             clr_open,
    output logic             idle,
    output logic             is_open
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             open;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld) begin
            st_d.cnt = ld_val;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (set_open) st_d.open = 1'b1;
        if (clr_open) st_d.open = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idle    = (st_q.cnt == '0);
    assign is_open = st_q.open;

    // A new window may only start once the previous one has expired.
    p_load_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ld |-> (st_q.cnt == '0));

    // Opening and closing never target the same bank on one edge.
    p_open_close_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_open && clr_open));

    // The open flag only rises when the top loaded a tRCD window.
    p_open_with_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.open) |-> $past(ld));

endmodule

// File: rtl/sdc_cmd_encode.sv
module sdc_cmd_encode
    import sdc_pkg::*;
#(
    parameter int BA_W   = 2,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 9,
    parameter int ADDR_W = 13,
    parameter int AP_BIT = 10
) (
    input  logic [2:0]        op,
    input  logic [BA_W-1:0]   bank,
    input  logic [ROW_W-1:0]  arg,
    input  logic              ap_eff,
    input  logic              pre_all,
    output logic [3:0]        pins,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);

    always_comb begin
        pins = PIN_NOP;
        ba   = '0;
        addr = '0;
        case (op_e'(op))
            OP_ACT: begin
                pins              = PIN_ACT;
                ba                = bank;
                addr[ROW_W-1:0]   = arg;
            end
            OP_RD, OP_WR: begin
                pins              = (op_e'(op) == OP_RD) ? PIN_RD : PIN_WR;
                ba                = bank;
                addr[COL_W-1:0]   = arg[COL_W-1:0];
                addr[AP_BIT]      = ap_eff;
            end
            OP_PRE: begin
                pins              = PIN_PRE;
                ba                = pre_all ? '0 : bank;
                addr[AP_BIT]      = pre_all;
            end
            OP_BST: pins = PIN_BST;
            OP_REF: pins = PIN_REF;
            OP_LMR: begin
                pins              = PIN_LMR;
                addr[ROW_W-1:0]   = arg;
            end
            default: pins = PIN_NOP;
        endcase
    end

endmodule

// File: rtl/sdram_cmd_issuer.sv
module sdram_cmd_issuer
    import sdc_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int COL_W     = 9,
    parameter int ADDR_W    = 13,
    parameter int AP_BIT    = 10,
    parameter int T_RP      = 3,
    parameter int T_RCD     = 2,
    parameter int BURST_LEN = 4,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_full_page,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [2:0]           req_op,
    input  logic [BA_W-1:0]      req_bank,
    input  logic [ROW_W-1:0]     req_arg,
    input  logic                 req_auto_pre,
    input  logic                 req_all,
    output logic                 sd_cs_n,
    output logic                 sd_ras_n,
    output logic                 sd_cas_n,
    output logic                 sd_we_n,
    output logic [BA_W-1:0]      sd_ba,
    output logic [ADDR_W-1:0]    sd_addr,
    output logic [NUM_BANKS-1:0] bank_open
);

    localparam int AP_HOLD = BURST_LEN + T_RP;
    localparam int CNT_W   = $clog2(AP_HOLD + 1);
    localparam logic [CNT_W-1:0] LD_RCD = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] LD_AP  = CNT_W'(AP_HOLD - 1);

    typedef struct packed {
        logic [3:0]        pins;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
    } out_t;

    out_t out_d, out_q;

    op_e                             op;
    logic                            sel_free, all_free, rdy, fire;
    logic                            ap_eff, pre_all;
    logic [NUM_BANKS-1:0]            bank_idle;
    logic [NUM_BANKS-1:0]            ld, set_open, clr_open;
    logic [NUM_BANKS-1:0][CNT_W-1:0] ld_val;
    logic [3:0]                      enc_pins;
    logic [BA_W-1:0]                 enc_ba;
    logic [ADDR_W-1:0]               enc_addr;

    // Request decode and acceptance
    always_comb begin
        op       = op_e'(req_op);
        sel_free = bank_idle[req_bank];
        all_free = &bank_idle;
        case (op)
            OP_ACT, OP_RD, OP_WR: rdy = sel_free;
            OP_PRE:               rdy = req_all ? all_free : sel_free;
            OP_BST:               rdy = 1'b1;
            OP_REF, OP_LMR:       rdy = all_free;
            default:              rdy = 1'b0;
        endcase
        ap_eff  = (op == OP_RD || op == OP_WR) && req_auto_pre && !cfg_full_page;
        pre_all = (op == OP_PRE) && req_all;
        fire    = req_valid && rdy;
    end

    // Per-bank window loads
    always_comb begin
        for (int i = 0; i < NUM_BANKS; i++) begin
            ld[i]       = 1'b0;
            ld_val[i]   = '0;
            set_open[i] = 1'b0;
            clr_open[i] = 1'b0;
            if (fire) begin
                case (op)
                    OP_ACT: if (req_bank == BA_W'(i)) begin
                        ld[i]       = 1'b1;
                        ld_val[i]   = LD_RCD;
                        set_open[i] = 1'b1;
                    end
                    OP_RD, OP_WR: if (req_bank == BA_W'(i) && ap_eff) begin
                        ld[i]       = 1'b1;
                        ld_val[i]   = LD_AP;
                        clr_open[i] = 1'b1;
                    end
                    OP_PRE: if (req_bank == BA_W'(i) || req_all) begin
                        ld[i]       = 1'b1;
                        ld_val[i]   = LD_RP;
                        clr_open[i] = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    generate
        for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
            sdc_bank_timer #(.CNT_W(CNT_W)) i_timer (
                .clk     (clk),
                .rst_n   (rst_n),
                .ld      (ld[g]),
                .ld_val  (ld_val[g]),
                .set_open(set_open[g]),
                .clr_open(clr_open[g]),
                .idle    (bank_idle[g]),
                .is_open (bank_open[g])
            );
        end
    endgenerate

    sdc_cmd_encode #(
        .BA_W  (BA_W),
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .ADDR_W(ADDR_W),
        .AP_BIT(AP_BIT)
    ) i_encode (
        .op     (req_op),
        .bank   (req_bank),
        .arg    (req_arg),
        .ap_eff (ap_eff),
        .pre_all(pre_all),
        .pins   (enc_pins),
        .ba     (enc_ba),
        .addr   (enc_addr)
    );

    always_comb begin
        out_d.pins = PIN_NOP;
        out_d.ba   = '0;
        out_d.addr = '0;
        if (fire) begin
            out_d.pins = enc_pins;
            out_d.ba   = enc_ba;
            out_d.addr = enc_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q.pins <= PIN_NOP;
            out_q.ba   <= '0;
            out_q.addr <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign req_ready = rdy;
    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = out_q.pins;
    assign sd_ba   = out_q.ba;
    assign sd_addr = out_q.addr;

    p_nop_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111));

    p_full_page_no_ap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && cfg_full_page && (req_op == 3'd1 || req_op == 3'd2))
        |=> !sd_addr[AP_BIT]);

    p_stop_never_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd4) |-> req_ready);

    p_single_bank_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !pre_all) |-> ($countones(ld) <= 1));

    p_close_all_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op == 3'd3 && req_all) |=> (bank_open == '0));

endmodule

// File: tb/test_sdram_cmd_issuer.sv
module test_sdram_cmd_issuer;

    localparam int CLK_PERIOD = 10;
    localparam int NB    = 4;
    localparam int BAW   = 2;
    localparam int T_RP  = 3;
    localparam int T_RCD = 2;
    localparam int BL    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_full_page = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [2:0] req_op = '0;
    logic [BAW-1:0] req_bank = '0;
    logic [11:0] req_arg = '0;
    logic req_auto_pre = 1'b0;
    logic req_all = 1'b0;
    logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [BAW-1:0] sd_ba;
    logic [12:0] sd_addr;
    logic [NB-1:0] bank_open;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [18:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_cmd_issuer #(
        .NUM_BANKS(NB), .T_RP(T_RP), .T_RCD(T_RCD), .BURST_LEN(BL)
    ) i_sdram_cmd_issuer (
        .clk(clk), .rst_n(rst_n), .cfg_full_page(cfg_full_page),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_bank(req_bank), .req_arg(req_arg), .req_auto_pre(req_auto_pre),
        .req_all(req_all), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
        .sd_addr(sd_addr), .bank_open(bank_open)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Expected pin image {cs,ras,cas,we, ba, addr} from the requirements.
    function automatic logic [18:0] expect_pins(input logic [2:0] op, input logic [1:0] bank,
                                                input logic [11:0] arg, input logic ap,
                                                input logic all, input logic fp);
        logic [3:0]  p;
        logic [1:0]  b;
        logic [12:0] a;
        p = 4'b0111; b = 2'd0; a = 13'd0;
        case (op)
            3'd0: begin p = 4'b0011; b = bank; a[11:0] = arg; end
            3'd1, 3'd2: begin
                p = (op == 3'd1) ? 4'b0101 : 4'b0100;
                b = bank; a[8:0] = arg[8:0]; a[10] = ap && !fp;
            end
            3'd3: begin p = 4'b0010; b = all ? 2'd0 : bank; a[10] = all; end
            3'd4: p = 4'b0110;
            3'd5: p = 4'b0001;
            3'd6: begin p = 4'b0000; a[11:0] = arg; end
            default: ;
        endcase
        return {p, b, a};
    endfunction

    // Driver: call just after a falling edge; returns the cycle of acceptance.
    task automatic issue(input logic [2:0] op, input logic [1:0] bank, input logic [11:0] arg,
                         input logic ap, input logic all, input string tag, output int t_acc);
        logic rdy;
        exp_q.push_back(expect_pins(op, bank, arg, ap, all, cfg_full_page));
        tag_q.push_back(tag);
        req_op = op; req_bank = bank; req_arg = arg;
        req_auto_pre = ap; req_all = all; req_valid = 1'b1;
        do begin
            #1 rdy = req_ready;
            @(posedge clk);
            @(negedge clk);
        end while (!rdy);
        req_valid = 1'b0;
        t_acc = cyc;
    endtask

    // Monitor: every non-NOP pin image must match the head of the scoreboard.
    always @(negedge clk) begin
        logic [18:0] got;
        got = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr};
        if (rst_n && got[18:15] != 4'b0111) begin
            if (exp_q.size() == 0) begin
                check("R2 unexpected command", {13'd0, got}, {13'd0, 4'b0111, 15'd0});
            end else begin
                logic [18:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {13'd0, got}, {13'd0, e});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired, all requirements: actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int t0, t1, t2, t3;
        repeat (3) @(negedge clk);
        check("R1 pins in reset", {28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 32'h7);
        check("R1 banks closed in reset", {28'd0, bank_open}, 32'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 idle NOP", {28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 32'h7);
        check("R1 banks closed after reset", {28'd0, bank_open}, 32'h0);

        issue(3'd0, 2'd0, 12'hABC, 1'b0, 1'b0, "R4 row open bank0", t0);
        check("R4 bank0 open", {31'd0, bank_open[0]}, 32'h1);
        issue(3'd1, 2'd0, 12'h1F3, 1'b0, 1'b0, "R5 read no close", t1);
        check("R10 read waits T_RCD", t1 - t0, T_RCD);
        issue(3'd2, 2'd0, 12'hEA5, 1'b1, 1'b0, "R5 write with close", t2);
        check("R3 write back-to-back", t2 - t1, 1);
        issue(3'd0, 2'd1, 12'h123, 1'b0, 1'b0, "R3 row open bank1", t3);
        check("R7 other bank not delayed", t3 - t2, 1);
        check("R9 bank0 closed by burst close", {31'd0, bank_open[0]}, 32'h0);
        issue(3'd0, 2'd0, 12'h456, 1'b0, 1'b0, "R4 reopen bank0", t0);
        check("R9 reopen waits BURST_LEN+T_RP", t0 - t2, BL + T_RP);
        issue(3'd1, 2'd0, 12'h011, 1'b0, 1'b0, "R5 close flag not persistent", t1);
        check("R10 second read waits T_RCD", t1 - t0, T_RCD);

        issue(3'd3, 2'd1, 12'h000, 1'b0, 1'b0, "R7 close bank1", t2);
        check("R7 bank1 closed, bank0 open", {30'd0, bank_open[1:0]}, 32'h1);
        issue(3'd0, 2'd1, 12'h0F0, 1'b0, 1'b0, "R3 reopen bank1", t3);
        check("R7 reopen waits T_RP", t3 - t2, T_RP);

        issue(3'd3, 2'd3, 12'h000, 1'b0, 1'b1, "R8 close all", t0);
        check("R8 all banks closed", {28'd0, bank_open}, 32'h0);
        issue(3'd4, 2'd2, 12'h7FF, 1'b1, 1'b0, "R12 burst stop", t1);
        check("R12 burst stop not held", t1 - t0, 1);
        issue(3'd5, 2'd0, 12'h000, 1'b0, 1'b0, "R11 refresh", t2);
        check("R11 refresh waits for close-all", t2 - t0, T_RP);
        issue(3'd6, 2'd0, 12'h237, 1'b0, 1'b0, "R11 mode load", t3);
        check("R11 mode load after refresh", t3 - t2, 1);

        cfg_full_page = 1'b1;
        issue(3'd0, 2'd2, 12'h3C3, 1'b0, 1'b0, "R4 row open bank2", t0);
        issue(3'd1, 2'd2, 12'h155, 1'b1, 1'b0, "R6 full-page read drops close", t1);
        issue(3'd2, 2'd2, 12'h0AA, 1'b1, 1'b0, "R6 full-page write drops close", t2);
        check("R6 bank2 not blocked", t2 - t1, 1);
        check("R6 bank2 stays open", {31'd0, bank_open[2]}, 32'h1);
        cfg_full_page = 1'b0;

        repeat (4) @(negedge clk);
        check("R2 NOP after traffic", {28'd0, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 32'h7);
        check("R3 scoreboard drained", exp_q.size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule